// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 96 level-sensitive interrupt lines into three 32-bit banks. It drives one normal-interrupt line (IRQ) and one fast-interrupt line (FIQ) to a processor. It also produces a vector: the byte offset of the lowest-numbered source that is pending and not masked. A processor reads the vector and jumps into a table of 4-byte entries. Each source can be steered to the fast line by its own select bit. A per-bank mask can silence any source without losing its pending state.

The host reaches the block through a flat 32-bit word port. A write takes effect on the clock edge where `wr_en_i` is high. A read returns data on `rdata_o` one clock after `rd_en_i`. The register space covers 0x400 bytes. It holds a vector word, a base-address word and a protect word, plus five banked groups: IRQ-pending, FIQ-pending, select, enable and mask. The enable words are stored and read back, but they do not gate either output.

Top module: `vic_top`

## Requirements
- R1: Each source is sampled on every clock edge. Pending bit (n mod 32) of bank (n div 32) equals the level that source n had at the previous edge, so it sets while the line is high and clears when it falls.
- R2: `irq_o` is high exactly when some pending bit has its mask bit at 0.
- R3: `fiq_o` is high exactly when some pending bit has its mask bit at 0 and its select bit at 1.
- R4: The vector word equals 4 × (32 × bank + bit) for the lowest-numbered pending, unmasked source. The lowest bank is searched first. The vector is 0 when no such source exists.
- R5: Word map by byte offset:
  - vector at 0x000, base address at 0x004, protect at 0x008;
  - IRQ-pending at 0x010, FIQ-pending at 0x020, select at 0x030, enable at 0x040, mask at 0x050.
  - Each banked group takes three words. Offset bits [3:2] choose the bank, and bits [1:0] are ignored.
  - Read data appears on `rdata_o` one clock after `rd_en_i`.
- R6: Writes to the IRQ-pending words change nothing. Reading them back still returns the live source state.
- R7: A FIQ-pending bit sets on any clock where its source is pending, unmasked and selected, and it stays set after the source falls. Writing a 1 to that bit clears it, and writing a 0 leaves it unchanged. If the source is still active in the cycle of the clearing write, the bit stays set.
- R8: The base-address word stores the written value with bits [1:0] forced to 0.
- R9: A read at any offset outside the map returns 0. A write there changes no stored word. This includes the unused fourth bank word of each group and the vector word.
- R10: While reset is low, all pending and FIQ-pending bits are cleared and both outputs are low. After reset, the vector, base, protect, select, enable and mask words read 0.
- R11: Select, enable and mask words store all 32 written bits for the addressed bank. The enable value has no effect on `irq_o`, `fiq_o` or the vector.
- R12: The protect word stores and returns all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 96 | Level-sensitive interrupt sources, one bit per source |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 10 | Byte offset into the register space |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one clock after `rd_en_i` |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
The hardest case to reach is the FIQ-pending write-one-to-clear racing against a source that is still active, steered to the fast line and unmasked in the same cycle. In that case the set must win. Getting there needs a select write, a mask write and a source level all lined up before the clearing write. Directed steps build exactly that state. Random rounds then mix sparse unmasked sources with random select patterns and occasional clearing writes, so that sticky bits build up and drain between reads. The vector search gets directed sources at bits 0, 31, 32 and 95. It also gets a masked low source with an active higher source behind it.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned LOW_W  = $clog2(WORD_W);

    // Register group numbers: byte offset bits above [3:2]
    localparam int unsigned GRP_CTRL = 0;
    localparam int unsigned GRP_IRQP = 1;
    localparam int unsigned GRP_FIQP = 2;
    localparam int unsigned GRP_SEL  = 3;
    localparam int unsigned GRP_EN   = 4;
    localparam int unsigned GRP_MASK = 5;

    typedef enum logic [3:0] {
        REG_NONE,
        REG_VEC,
        REG_BASE,
        REG_PROT,
        REG_IRQP,
        REG_FIQP,
        REG_SEL,
        REG_EN,
        REG_MASK
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [1:0]  bank;
    } reg_hit_t;

endpackage

// File: rtl/vic_decode.sv
module vic_decode
    import vic_pkg::*;
#(
    parameter int unsigned AW       = 10,
    parameter int unsigned NUM_BANK = 3
) (
    input  logic [AW-1:0] addr_i,
    output reg_hit_t      hit_o
);

    logic [AW-5:0] grp;
    logic [1:0]    bsel;
    logic          bank_ok;

    assign grp     = addr_i[AW-1:4];
    assign bsel    = addr_i[3:2];
    assign bank_ok = (32'(bsel) < NUM_BANK);

    always_comb begin
        hit_o.kind = REG_NONE;
        hit_o.bank = bsel;
        if (32'(grp) == GRP_CTRL) begin
            unique case (bsel)
                2'd0:    hit_o.kind = REG_VEC;
                2'd1:    hit_o.kind = REG_BASE;
                2'd2:    hit_o.kind = REG_PROT;
                default: hit_o.kind = REG_NONE;
            endcase
        end else if (bank_ok) begin
            if      (32'(grp) == GRP_IRQP) hit_o.kind = REG_IRQP;
            else if (32'(grp) == GRP_FIQP) hit_o.kind = REG_FIQP;
            else if (32'(grp) == GRP_SEL)  hit_o.kind = REG_SEL;
            else if (32'(grp) == GRP_EN)   hit_o.kind = REG_EN;
            else if (32'(grp) == GRP_MASK) hit_o.kind = REG_MASK;
            else                           hit_o.kind = REG_NONE;
        end
    end

endmodule

// File: rtl/vic_bank.sv
module vic_bank
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] src_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              we_fiqp_i,
    input  logic              we_sel_i,
    input  logic              we_en_i,
    input  logic              we_mask_i,
    output logic [WORD_W-1:0] pend_o,
    output logic [WORD_W-1:0] fiqp_o,
    output logic [WORD_W-1:0] sel_o,
    output logic [WORD_W-1:0] en_o,
    output logic [WORD_W-1:0] mask_o,
    output logic [WORD_W-1:0] act_o,
    output logic [WORD_W-1:0] fact_o
);

    logic [WORD_W-1:0] clr_bits;

    assign act_o    = pend_o & ~mask_o;
    assign fact_o   = act_o & sel_o;
    assign clr_bits = we_fiqp_i ? wdata_i : '0;

    // Source sampling and sticky fast-pending capture (set wins over clear)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_o <= '0;
            fiqp_o <= '0;
        end else begin
            pend_o <= src_i;
            fiqp_o <= (fiqp_o & ~clr_bits) | fact_o;
        end
    end

    // Host-written words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_o  <= '0;
            en_o   <= '0;
            mask_o <= '0;
        end else begin
            if (we_sel_i)  sel_o  <= wdata_i;
            if (we_en_i)   en_o   <= wdata_i;
            if (we_mask_i) mask_o <= wdata_i;
        end
    end

endmodule

// File: rtl/vic_vector.sv
module vic_vector
    import vic_pkg::*;
#(
    parameter int unsigned NUM_BANK = 3
) (
    input  logic [NUM_BANK*WORD_W-1:0] act_i,
    output logic [WORD_W-1:0]          vec_o
);

    logic [NUM_BANK-1:0] bank_any;
    logic [LOW_W-1:0]    bank_low [NUM_BANK];

    // Lowest active bit inside each bank
    always_comb begin
        for (int b = 0; b < NUM_BANK; b++) begin
            bank_any[b] = |act_i[b*WORD_W +: WORD_W];
            bank_low[b] = '0;
            for (int i = WORD_W - 1; i >= 0; i--) begin
                if (act_i[b*WORD_W + i]) bank_low[b] = LOW_W'(i);
            end
        end
    end

    // Lowest bank with any active bit wins
    always_comb begin
        vec_o = '0;
        for (int b = NUM_BANK - 1; b >= 0; b--) begin
            if (bank_any[b]) begin
                vec_o = WORD_W'((b * WORD_W + int'(bank_low[b])) * 4);
            end
        end
    end

endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 96,
    parameter int unsigned AW      = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [AW-1:0]      addr_i,
    input  logic [WORD_W-1:0]  wdata_i,
    output logic [WORD_W-1:0]  rdata_o,
    output logic               irq_o,
    output logic               fiq_o
);

    localparam int unsigned NUM_BANK = (NUM_SRC + WORD_W - 1) / WORD_W;
    localparam int unsigned PAD      = NUM_BANK * WORD_W;

    reg_hit_t          hit;
    logic [PAD-1:0]    src_pad;
    logic [PAD-1:0]    pend_flat, fiqp_flat, sel_flat, en_flat, mask_flat;
    logic [PAD-1:0]    act_flat, fact_flat;
    logic [WORD_W-1:0] vec_w;
    logic [WORD_W-1:0] base_q, prot_q;
    logic [WORD_W-1:0] rd_mux;

    always_comb begin
        src_pad              = '0;
        src_pad[NUM_SRC-1:0] = src_i;
    end

    vic_decode #(.AW(AW), .NUM_BANK(NUM_BANK)) u_dec (
        .addr_i (addr_i),
        .hit_o  (hit)
    );

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        logic bank_hit;
        assign bank_hit = wr_en_i && (32'(hit.bank) == b);

        vic_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (src_pad[b*WORD_W +: WORD_W]),
            .wdata_i   (wdata_i),
            .we_fiqp_i (bank_hit && hit.kind == REG_FIQP),
            .we_sel_i  (bank_hit && hit.kind == REG_SEL),
            .we_en_i   (bank_hit && hit.kind == REG_EN),
            .we_mask_i (bank_hit && hit.kind == REG_MASK),
            .pend_o    (pend_flat[b*WORD_W +: WORD_W]),
            .fiqp_o    (fiqp_flat[b*WORD_W +: WORD_W]),
            .sel_o     (sel_flat[b*WORD_W +: WORD_W]),
            .en_o      (en_flat[b*WORD_W +: WORD_W]),
            .mask_o    (mask_flat[b*WORD_W +: WORD_W]),
            .act_o     (act_flat[b*WORD_W +: WORD_W]),
            .fact_o    (fact_flat[b*WORD_W +: WORD_W])
        );
    end

    vic_vector #(.NUM_BANK(NUM_BANK)) u_vec (
        .act_i (act_flat),
        .vec_o (vec_w)
    );

    assign irq_o = |act_flat;
    assign fiq_o = |fact_flat;

    // Control words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            prot_q <= '0;
        end else if (wr_en_i) begin
            if (hit.kind == REG_BASE) base_q <= {wdata_i[WORD_W-1:2], 2'b00};
            if (hit.kind == REG_PROT) prot_q <= wdata_i;
        end
    end

    // Read multiplexer
    always_comb begin
        unique case (hit.kind)
            REG_VEC:  rd_mux = vec_w;
            REG_BASE: rd_mux = base_q;
            REG_PROT: rd_mux = prot_q;
            REG_IRQP: rd_mux = pend_flat[hit.bank*WORD_W +: WORD_W];
            REG_FIQP: rd_mux = fiqp_flat[hit.bank*WORD_W +: WORD_W];
            REG_SEL:  rd_mux = sel_flat[hit.bank*WORD_W +: WORD_W];
            REG_EN:   rd_mux = en_flat[hit.bank*WORD_W +: WORD_W];
            REG_MASK: rd_mux = mask_flat[hit.bank*WORD_W +: WORD_W];
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_o <= '0;
        else if (rd_en_i) rdata_o <= rd_mux;
    end

endmodule

// File: rtl/vic_top_chk.sv
module vic_top_chk #(
    parameter int unsigned NUM_SRC = 96,
    parameter int unsigned PAD     = 96
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [PAD-1:0]     pend_flat,
    input  logic [PAD-1:0]     act_flat,
    input  logic [31:0]        vec_w,
    input  logic [31:0]        base_q,
    input  logic               irq_o,
    input  logic               fiq_o
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r1_pend_tracks_src: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (pend_flat[NUM_SRC-1:0] == $past(src_i)));

    a_r2_irq_has_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_flat != '0));

    a_r3_fiq_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> irq_o);

    a_r4_vec_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vec_w == 32'd0));

    a_r4_vec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_w[1:0] == 2'b00 && vec_w < 32'(NUM_SRC * 4)));

    a_r4_vec_points_active: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> act_flat[vec_w >> 2]);

    a_r8_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        base_q[1:0] == 2'b00);

endmodule

bind vic_top vic_top_chk #(.NUM_SRC(NUM_SRC), .PAD(PAD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .pend_flat (pend_flat),
    .act_flat  (act_flat),
    .vec_w     (vec_w),
    .base_q    (base_q),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
);

// File: tb/vic_top_tb_top.sv
module vic_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 96;

    localparam logic [9:0] A_VEC  = 10'h000;
    localparam logic [9:0] A_BASE = 10'h004;
    localparam logic [9:0] A_PROT = 10'h008;
    localparam logic [9:0] A_IRQP = 10'h010;
    localparam logic [9:0] A_FIQP = 10'h020;
    localparam logic [9:0] A_SEL  = 10'h030;
    localparam logic [9:0] A_EN   = 10'h040;
    localparam logic [9:0] A_MASK = 10'h050;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic            wr_en = 1'b0, rd_en = 1'b0;
    logic [9:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            irq, fiq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [NSRC-1:0] m_src = '0, m_sel = '0, m_en = '0, m_mask = '0, m_fiqp = '0;
    logic [31:0]     m_base = '0, m_prot = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vic_top dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
    );

    function automatic logic [NSRC-1:0] m_act();
        return m_src & ~m_mask;
    endfunction

    function automatic logic [31:0] m_vec();
        logic [NSRC-1:0] a = m_act();
        for (int n = NSRC - 1; n >= 0; n--) begin
            if (a[n]) m_vec = 32'(n * 4);
        end
        if (a == '0) m_vec = 32'd0;
    endfunction

    task automatic settle();
        m_fiqp = m_fiqp | (m_src & ~m_mask & m_sel);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic put(input logic [9:0] a, input logic [31:0] d);
        int b;
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        b = int'(a[3:2]);
        if (b < 3) begin
            case (a[9:4])
                6'd2: m_fiqp[b*32 +: 32] = m_fiqp[b*32 +: 32] & ~d;
                6'd3: m_sel[b*32 +: 32]  = d;
                6'd4: m_en[b*32 +: 32]   = d;
                6'd5: m_mask[b*32 +: 32] = d;
                default: ;
            endcase
        end
        if (a == A_BASE) m_base = {d[31:2], 2'b00};
        if (a == A_PROT) m_prot = d;
        settle();
    endtask

    task automatic get(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic drive_src(input logic [NSRC-1:0] v);
        @(negedge clk);
        src = v;
        m_src = v;
        @(negedge clk);
        @(negedge clk);
        settle();
    endtask

    task automatic check_outputs(input string tag);
        logic [31:0] d;
        check({tag, " R2 irq"}, 32'(irq), 32'(|m_act()));
        check({tag, " R3 fiq"}, 32'(fiq), 32'(|(m_act() & m_sel)));
        get(A_VEC, d);
        check({tag, " R4 vector"}, d, m_vec());
    endtask

    task automatic check_banks(input string tag);
        logic [31:0] d;
        for (int b = 0; b < 3; b++) begin
            get(A_IRQP + 10'(b*4), d); check({tag, " R1 pending"}, d, m_src[b*32 +: 32]);
            get(A_FIQP + 10'(b*4), d); check({tag, " R7 fiq pending"}, d, m_fiqp[b*32 +: 32]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check("R10 irq", 32'(irq), 0);
        check("R10 fiq", 32'(fiq), 0);
        get(A_VEC, d);  check("R10 vector", d, 0);
        get(A_BASE, d); check("R10 base", d, 0);
        get(A_PROT, d); check("R10 protect", d, 0);
        for (int b = 0; b < 3; b++) begin
            get(A_SEL + 10'(b*4), d);  check("R10 select", d, 0);
            get(A_EN + 10'(b*4), d);   check("R10 enable", d, 0);
            get(A_MASK + 10'(b*4), d); check("R10 mask", d, 0);
            get(A_FIQP + 10'(b*4), d); check("R10 fiq pending", d, 0);
        end

        // R5 / R11: banked read-back with distinct values
        for (int b = 0; b < 3; b++) begin
            put(A_SEL + 10'(b*4), 32'h5100_0000 + 32'(b));
            put(A_EN + 10'(b*4), 32'hE000_00F0 + 32'(b));
            put(A_MASK + 10'(b*4), 32'h3A00_0C00 + 32'(b));
        end
        for (int b = 0; b < 3; b++) begin
            get(A_SEL + 10'(b*4), d);  check("R5 R11 select bank", d, m_sel[b*32 +: 32]);
            get(A_EN + 10'(b*4), d);   check("R5 R11 enable bank", d, m_en[b*32 +: 32]);
            get(A_MASK + 10'(b*4), d); check("R5 R11 mask bank", d, m_mask[b*32 +: 32]);
        end
        for (int b = 0; b < 3; b++) begin
            put(A_SEL + 10'(b*4), 0);
            put(A_MASK + 10'(b*4), 0);
        end

        // R8, R12
        put(A_BASE, 32'hFFFF_FFFF); get(A_BASE, d); check("R8 base low bits", d, 32'hFFFF_FFFC);
        put(A_BASE, 32'h1234_5677); get(A_BASE, d); check("R8 base value", d, m_base);
        put(A_PROT, 32'hA5A5_0003); get(A_PROT, d); check("R12 protect", d, 32'hA5A5_0003);

        // R9: undecoded offsets
        put(10'h3FC, 32'hFFFF_FFFF); get(10'h3FC, d); check("R9 far offset", d, 0);
        put(10'h00C, 32'hFFFF_FFFF); get(10'h00C, d); check("R9 ctrl gap", d, 0);
        put(10'h05C, 32'hFFFF_FFFF); get(10'h05C, d); check("R9 mask bank3", d, 0);
        put(A_VEC, 32'hFFFF_FFFF);
        for (int b = 0; b < 3; b++) begin
            get(A_MASK + 10'(b*4), d); check("R9 mask untouched", d, 0);
        end
        get(A_BASE, d); check("R9 base untouched", d, m_base);
        get(A_PROT, d); check("R9 protect untouched", d, m_prot);
        check("R9 irq untouched", 32'(irq), 0);

        // R6: IRQ-pending is read-only
        drive_src({32'h0000_8000, 32'h0, 32'h0000_0010});
        put(A_IRQP, 32'hFFFF_FFFF);
        put(A_IRQP + 10'd8, 32'h0);
        get(A_IRQP, d);        check("R6 irq pending bank0", d, 32'h0000_0010);
        get(A_IRQP + 10'd8, d); check("R6 irq pending bank2", d, 32'h0000_8000);
        check_outputs("R6");

        // R4: vector corners
        drive_src(96'd1 << 95); check_outputs("R4 src95");
        drive_src(96'd1);       check_outputs("R4 src0");
        drive_src((96'd1 << 31) | (96'd1 << 70)); check_outputs("R4 src31");
        drive_src((96'd1 << 32) | (96'd1 << 64)); check_outputs("R4 src32");
        put(A_MASK + 10'd4, 32'h0000_0001); check_outputs("R4 masked low");
        put(A_MASK + 10'd8, 32'h0000_0001); check_outputs("R4 all masked");
        put(A_MASK + 10'd4, 0); put(A_MASK + 10'd8, 0);
        drive_src('0); check_outputs("R1 release");

        // R7: fast pending capture, stickiness, write-one-to-clear
        put(A_SEL + 10'd4, 32'h0000_0300);
        drive_src(96'd3 << 40);
        check("R3 fiq selected", 32'(fiq), 1);
        get(A_FIQP + 10'd4, d); check("R7 captured", d, 32'h0000_0300);
        drive_src('0);
        get(A_FIQP + 10'd4, d); check("R7 sticky", d, 32'h0000_0300);
        put(A_FIQP + 10'd4, 32'h0000_0100);
        get(A_FIQP + 10'd4, d); check("R7 one clears", d, 32'h0000_0200);
        put(A_FIQP + 10'd4, 32'h0);
        get(A_FIQP + 10'd4, d); check("R7 zero keeps", d, 32'h0000_0200);
        drive_src(96'd1 << 41);
        put(A_FIQP + 10'd4, 32'hFFFF_FFFF);
        get(A_FIQP + 10'd4, d); check("R7 set wins", d, 32'h0000_0200);
        put(A_MASK + 10'd4, 32'h0000_0200);
        put(A_FIQP + 10'd4, 32'hFFFF_FFFF);
        get(A_FIQP + 10'd4, d); check("R7 masked clears", d, 32'h0);
        check("R3 masked fiq", 32'(fiq), 0);
        put(A_MASK + 10'd4, 0);

        // R11: enable does not gate outputs
        drive_src(96'd1 << 77);
        for (int b = 0; b < 3; b++) put(A_EN + 10'(b*4), 32'h0);
        check_outputs("R11 enable zero");
        for (int b = 0; b < 3; b++) put(A_EN + 10'(b*4), 32'hFFFF_FFFF);
        check_outputs("R11 enable ones");

        // Random rounds
        for (int it = 0; it < 60; it++) begin
            for (int b = 0; b < 3; b++) begin
                put(A_MASK + 10'(b*4), $urandom | $urandom | $urandom);
                put(A_SEL + 10'(b*4), $urandom);
            end
            if ((it % 4) == 3) put(A_FIQP + 10'(4 * ($urandom % 3)), $urandom);
            drive_src({$urandom, $urandom, $urandom});
            check_outputs("rand");
            check_banks("rand");
        end

        // R10: reset in mid-run
        drive_src(96'hFFFF_0000_0000_0000_0000_00FF);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 irq in reset", 32'(irq), 0);
        check("R10 fiq in reset", 32'(fiq), 0);
        m_sel = '0; m_en = '0; m_mask = '0; m_fiqp = '0; m_base = '0; m_prot = '0;
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        settle();
        get(A_BASE, d); check("R10 base after reset", d, 0);
        get(A_PROT, d); check("R10 protect after reset", d, 0);
        check_outputs("R10 relatch");
        check_banks("R10 relatch");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule